// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Arbiter

This block gathers eleven maskable interrupt request lines and one software-trap line. It latches each request and ranks the eligible ones by a fixed order. When any of them may be taken, it raises a request to the core. Whatever the source, the core is sent to a single shared entry address, 0x00FF. The source of the interrupt is chosen at that moment and held until the core resolves it.

The handler at the shared entry then issues a vector-select strobe. The arbiter answers it with a table address: a vector base plus twice the winning slot, so each table entry is a 16-bit address word. The source that was served has its pending bit cleared. A strobe issued while nothing is eligible returns the default vector, which has the lowest rank. The global enable is set and cleared by the core and is dropped automatically each time an interrupt is taken.

Top module: `irq_vis_arbiter`

## Requirements
- R1: After synchronous reset, irq_o, gie_o, vec_valid_o, entry_o, win_slot_o and vec_o are all zero, and no request is pending.
- R2: A request is latched as pending only when its line is sampled high after being sampled low. A line held high does not latch again after its pending bit is cleared. It latches again only after it falls and rises once more.
- R3: A maskable source i is eligible only when it is pending, en_i[i] is 1 and gie_o is 1. A pending software trap is eligible regardless of en_i and gie_o.
- R4: Slot encoding: the software trap is slot 0, maskable source i is slot i+1, and the default vector is slot 12. Among eligible requests, the lowest slot wins.
- R5: When irq_o is low, vsel_i is low and at least one request is eligible, the next clock edge does three things. It raises irq_o, loads win_slot_o with the winner and drives entry_o to 0x00FF. The same edge clears gie_o, and this clear overrides gie_set_i in that cycle.
- R6: While irq_o is high, win_slot_o does not change, even if requests of higher rank arrive.
- R7: Each vsel_i cycle gives a one-cycle vec_valid_o pulse on the next cycle, with vec_o = 0x0E00 + 2 x slot. The slot is the held winner when irq_o was high, and otherwise the current winner. irq_o falls on that same edge.
- R8: A vsel_i with no eligible request returns slot 12 (vec_o = 0x0E18) and clears no pending bit. Masked pending requests remain pending.
- R9: A vsel_i clears only the pending bit of the slot it returns. Other pending requests stay latched and are taken in rank order afterwards.
- R10: gie_set_i sets gie_o and gie_clr_i clears it, each on the next edge. With gie_o low, no maskable request raises irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 11 | Maskable request lines; bit i is source i |
| en_i | input | 11 | Per-source enable bits |
| trap_i | input | 1 | Software-trap request line |
| gie_set_i | input | 1 | Set the global enable |
| gie_clr_i | input | 1 | Clear the global enable |
| vsel_i | input | 1 | Vector-select strobe; also acknowledges the returned source |
| irq_o | output | 1 | Interrupt taken; high until vector select |
| entry_o | output | 16 | Shared entry address while irq_o is high, else zero |
| win_slot_o | output | 4 | Held winning slot |
| gie_o | output | 1 | Global enable state |
| vec_valid_o | output | 1 | One-cycle pulse marking vec_o as fresh |
| vec_o | output | 16 | Vector table address returned by vector select |

## Verification
A pending bit that fails to clear shows up one cycle after the next gie_set_i as a second irq_o with the same slot. A pending bit that clears when it should not shows up as a missing irq_o or a default vector at the next vector select. An error in the winner register appears in win_slot_o on the cycle irq_o rises, and in vec_o one cycle after vsel_i. An enable that leaks past gie_o or en_i raises irq_o two cycles after the request edge.

// File: rtl/irq_vis_pkg.sv
package irq_vis_pkg;
  parameter int unsigned DEF_N_SRC  = 11;
  parameter int unsigned DEF_ADDR_W = 16;
  parameter logic [15:0] DEF_ENTRY  = 16'h00FF;
  parameter logic [15:0] DEF_VBASE  = 16'h0E00;

  // slots: 0 = trap, 1..N = maskable sources, N+1 = default
  function automatic int unsigned slot_count(input int unsigned n_src);
    return n_src + 2;
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] raw_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        raw_q[g]  <= 1'b0;
        pend_o[g] <= 1'b0;
      end else begin
        raw_q[g] <= raw_i[g];
        if (raw_i[g] && !raw_q[g])
          pend_o[g] <= 1'b1;
        else if (clr_i[g])
          pend_o[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned W      = 12,
  parameter int unsigned SLOT_W = 4
) (
  input  logic [W-1:0]      elig_i,
  output logic              any_o,
  output logic [SLOT_W-1:0] slot_o
);
  always_comb begin
    any_o  = 1'b0;
    slot_o = SLOT_W'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        any_o  = 1'b1;
        slot_o = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
  parameter int unsigned       ADDR_W = 16,
  parameter int unsigned       SLOT_W = 4,
  parameter logic [ADDR_W-1:0] VBASE  = '0
) (
  input  logic [SLOT_W-1:0] slot_i,
  output logic [ADDR_W-1:0] vec_o
);
  assign vec_o = VBASE + ADDR_W'({slot_i, 1'b0});
endmodule

// File: rtl/irq_vis_arbiter.sv
module irq_vis_arbiter
  import irq_vis_pkg::*;
#(
  parameter int unsigned       N_SRC  = DEF_N_SRC,
  parameter int unsigned       ADDR_W = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] ENTRY  = ADDR_W'(DEF_ENTRY),
  parameter logic [ADDR_W-1:0] VBASE  = ADDR_W'(DEF_VBASE),
  localparam int unsigned      W      = N_SRC + 1,
  localparam int unsigned      SLOT_W = $clog2(slot_count(N_SRC))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  req_i,
  input  logic [N_SRC-1:0]  en_i,
  input  logic              trap_i,
  input  logic              gie_set_i,
  input  logic              gie_clr_i,
  input  logic              vsel_i,
  output logic              irq_o,
  output logic [ADDR_W-1:0] entry_o,
  output logic [SLOT_W-1:0] win_slot_o,
  output logic              gie_o,
  output logic              vec_valid_o,
  output logic [ADDR_W-1:0] vec_o
);
  logic [W-1:0]      pend, elig, ack;
  logic              any_elig;
  logic [SLOT_W-1:0] cur_slot, sel_slot;
  logic [ADDR_W-1:0] sel_vec;

  irq_pend_bank #(.W(W)) u_pend (
    .clk   (clk),
    .rst   (rst),
    .raw_i ({req_i, trap_i}),
    .clr_i (ack),
    .pend_o(pend)
  );

  assign elig = pend & {en_i & {N_SRC{gie_o}}, 1'b1};

  irq_prio_enc #(.W(W), .SLOT_W(SLOT_W)) u_enc (
    .elig_i(elig),
    .any_o (any_elig),
    .slot_o(cur_slot)
  );

  assign sel_slot = irq_o ? win_slot_o : cur_slot;

  for (genvar g = 0; g < W; g++) begin : g_ack
    assign ack[g] = vsel_i && (sel_slot == SLOT_W'(g));
  end

  irq_vec_map #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .VBASE(VBASE)) u_vec (
    .slot_i(sel_slot),
    .vec_o (sel_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o       <= 1'b0;
      entry_o     <= '0;
      win_slot_o  <= '0;
      gie_o       <= 1'b0;
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
    end else begin
      vec_valid_o <= 1'b0;
      if (gie_set_i) gie_o <= 1'b1;
      if (gie_clr_i) gie_o <= 1'b0;
      if (vsel_i) begin
        vec_valid_o <= 1'b1;
        vec_o       <= sel_vec;
        irq_o       <= 1'b0;
        entry_o     <= '0;
      end else if (!irq_o && any_elig) begin
        irq_o      <= 1'b1;
        entry_o    <= ENTRY;
        win_slot_o <= cur_slot;
        gie_o      <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_vis_chk.sv
module irq_vis_chk #(
  parameter int unsigned       N_SRC  = 11,
  parameter int unsigned       ADDR_W = 16,
  parameter int unsigned       SLOT_W = 4,
  parameter logic [ADDR_W-1:0] ENTRY  = '0,
  parameter logic [ADDR_W-1:0] VBASE  = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              vsel_i,
  input logic              irq_o,
  input logic              gie_o,
  input logic [SLOT_W-1:0] win_slot_o,
  input logic [ADDR_W-1:0] entry_o,
  input logic              vec_valid_o,
  input logic [ADDR_W-1:0] vec_o
);
  localparam logic [ADDR_W-1:0] VTOP = VBASE + ADDR_W'(2 * (N_SRC + 1));

  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (rst) irq_o |-> entry_o == ENTRY); // R5
  AST_ACCEPT_GIE: assert property (@(posedge clk) disable iff (rst) $rose(irq_o) |-> !gie_o); // R5
  AST_SLOT_HELD: assert property (@(posedge clk) disable iff (rst) (irq_o && !vsel_i) |=> $stable(win_slot_o)); // R6
  AST_VV_PULSE: assert property (@(posedge clk) disable iff (rst) vsel_i |=> vec_valid_o); // R7
  AST_VV_ONLY: assert property (@(posedge clk) disable iff (rst) !vsel_i |=> !vec_valid_o); // R7
  AST_VSEL_DROP: assert property (@(posedge clk) disable iff (rst) vsel_i |=> !irq_o); // R7
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst) irq_o |-> win_slot_o <= SLOT_W'(N_SRC)); // R4
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst) vec_valid_o |-> (!vec_o[0] && vec_o >= VBASE && vec_o <= VTOP)); // R4
endmodule

bind irq_vis_arbiter irq_vis_chk #(
  .N_SRC(N_SRC), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .ENTRY(ENTRY), .VBASE(VBASE)
) u_chk (
  .clk(clk), .rst(rst), .vsel_i(vsel_i), .irq_o(irq_o), .gie_o(gie_o),
  .win_slot_o(win_slot_o), .entry_o(entry_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
);

// File: tb/sim_irq_vis_arbiter.sv
module sim_irq_vis_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] req_i = '0, en_i = '0;
  logic        trap_i = 0, gie_set_i = 0, gie_clr_i = 0, vsel_i = 0;
  logic        irq_o, gie_o, vec_valid_o;
  logic [15:0] entry_o, vec_o;
  logic [3:0]  win_slot_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_vis_arbiter u0 (
    .clk(clk), .rst(rst), .req_i(req_i), .en_i(en_i), .trap_i(trap_i),
    .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i), .vsel_i(vsel_i),
    .irq_o(irq_o), .entry_o(entry_o), .win_slot_o(win_slot_o), .gie_o(gie_o),
    .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );

  // {en, trap, req, expected slot}; slot 12 = no interrupt taken
  localparam logic [26:0] ROWS [0:7] = '{
    {11'h7FF, 1'b0, 11'h001, 4'd1},
    {11'h7FF, 1'b0, 11'h400, 4'd11},
    {11'h7FF, 1'b0, 11'h088, 4'd4},
    {11'h7F7, 1'b0, 11'h088, 4'd8},
    {11'h7FF, 1'b1, 11'h001, 4'd0},
    {11'h000, 1'b1, 11'h000, 4'd0},
    {11'h000, 1'b0, 11'h7FF, 4'd12},
    {11'h7FF, 1'b0, 11'h7FE, 4'd2}
  };

  function automatic logic [15:0] vexp(input int s);
    return 16'h0E00 + 16'(2 * s);
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; req_i = '0; en_i = '0; trap_i = 0;
    gie_set_i = 0; gie_clr_i = 0; vsel_i = 0;
    tick(2); rst = 0;
  endtask

  task automatic gie_on();
    gie_set_i = 1; tick(); gie_set_i = 0;
  endtask

  task automatic pulse_req(input logic [10:0] r, input logic t);
    req_i = r; trap_i = t; tick(); req_i = '0; trap_i = 0;
  endtask

  task automatic vsel_check(input int s, input string r);
    vsel_i = 1; tick(); vsel_i = 0;
    chk(vec_valid_o === 1'b1, r, vec_valid_o, 1);
    chk(vec_o === vexp(s), r, vec_o, vexp(s));
    chk(irq_o === 1'b0, r, irq_o, 0);
  endtask

  task automatic irq_check(input int s, input string r);
    chk(irq_o === 1'b1, r, irq_o, 1);
    chk(win_slot_o === 4'(s), r, win_slot_o, s);
    chk(entry_o === 16'h00FF, r, entry_o, 16'h00FF);
    chk(gie_o === 1'b0, "R5 gie auto clear", gie_o, 0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(irq_o === 0 && gie_o === 0 && vec_valid_o === 0, "R1 flags", {irq_o, gie_o, vec_valid_o}, 0);
    chk(entry_o === 0 && vec_o === 0 && win_slot_o === 0, "R1 values", {entry_o, vec_o}, 0);

    // table walk: R3 R4 R5 R7
    foreach (ROWS[k]) begin
      do_reset();
      en_i = ROWS[k][26:16];
      gie_on();
      pulse_req(ROWS[k][14:4], ROWS[k][15]);
      tick();
      if (ROWS[k][3:0] == 4'd12) begin
        chk(irq_o === 1'b0, "R3 masked no irq", irq_o, 0);
        vsel_check(12, "R8 default vector");
      end else begin
        irq_check(ROWS[k][3:0], "R4 winner");
        vsel_check(ROWS[k][3:0], "R7 vector");
      end
    end

    // R10: no global enable -> no irq; R8 masked pending survives default select
    do_reset();
    en_i = '1;
    pulse_req(11'h001, 0);
    tick(3);
    chk(irq_o === 1'b0, "R10 gie low blocks", irq_o, 0);
    en_i = '0;
    vsel_check(12, "R8 default with masked pending");
    en_i = '1;
    gie_on();
    tick();
    irq_check(1, "R8 pending kept");
    vsel_check(1, "R7 vector");

    // R10 clear
    gie_on();
    chk(gie_o === 1'b1, "R10 set", gie_o, 1);
    gie_clr_i = 1; tick(); gie_clr_i = 0;
    chk(gie_o === 1'b0, "R10 clear", gie_o, 0);
    pulse_req(11'h004, 0);
    tick(2);
    chk(irq_o === 1'b0, "R10 cleared blocks", irq_o, 0);

    // R2: held level does not re-latch
    do_reset();
    en_i = '1;
    gie_on();
    req_i = 11'h001;
    tick(2);
    irq_check(1, "R2 first edge");
    vsel_check(1, "R2 vector");
    gie_on();
    tick(3);
    chk(irq_o === 1'b0, "R2 held level no relatch", irq_o, 0);
    req_i = '0; tick();
    req_i = 11'h001; tick(2);
    irq_check(1, "R2 new edge");
    req_i = '0;

    // R9: ack clears only the served source
    do_reset();
    en_i = '1;
    gie_on();
    pulse_req(11'h006, 0);
    tick();
    irq_check(2, "R9 first");
    vsel_check(2, "R9 vector first");
    gie_on();
    tick();
    irq_check(3, "R9 second kept");
    vsel_check(3, "R9 vector second");
    vsel_check(12, "R8 nothing left");

    // R6: winner held while a trap arrives, trap taken next
    do_reset();
    en_i = '1;
    gie_on();
    pulse_req(11'h010, 0);
    tick();
    irq_check(5, "R6 accept");
    pulse_req(11'h000, 1);
    tick(2);
    chk(win_slot_o === 4'd5, "R6 held", win_slot_o, 5);
    vsel_check(5, "R6 vector of held slot");
    tick();
    irq_check(0, "R3 trap unmasked by gie");
    vsel_check(0, "R4 trap vector");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule